// File: doc/BRIEF.md
# Scanline Sprite Selector

This block picks, for one display line, the sprites that must be drawn on it. It holds a table of 64 sprite records, four bytes each, which a host fills through a byte-wide port: the host loads a byte pointer, then streams data writes that land at the pointer and advance it. Reads at the pointer leave it where it is. A start strobe, together with the line number and a small/large sprite select, launches one pass over the whole table.

Each pass first sets a 32-byte result buffer to all ones (0xFF in every byte). It then looks at one sprite per clock, lowest index first. Every sprite whose vertical span covers the line is copied whole into the next free result slot, up to eight. A ninth covering sprite raises a sticky overflow flag and ends the pass at once. The flag is held until a frame-start clear pulse. A done flag marks the end of the pass, and a hit count shows how many slots are filled so far. Any byte of the result buffer can be read through a byte selector.

The controller runs four states. IDLE is the state after reset, and start moves it to WIPE. WIPE lasts one cycle, fills the buffer with ones, clears the hit count and rewinds the sprite index, then always moves to SCAN. SCAN tests one sprite per cycle. It leaves for DONE either on the last sprite or on a covering sprite found while all eight slots are full. DONE holds the done flag, and start moves it back to WIPE.

Top module: `sprite_line_scanner`

## Requirements
- R1: `host_addr_wr` loads the byte pointer from `host_wdata`. Each `host_data_wr` stores `host_wdata` at the pointer and then adds one, wrapping from 255 to 0. `host_rdata` always shows the byte at the pointer, and reading it never moves the pointer.
- R2: Sprite n occupies table bytes 4n to 4n+3, holding in turn its top line Y, tile number, attribute and horizontal position. Result slot s occupies `sec_sel` values 4s to 4s+3 in the same byte order.
- R3: A sprite covers line L when L >= Y and L - Y is less than the height. The sum Y + height does not wrap past 255.
- R4: The height is 16 lines when `tall_sprites` is 1 and 8 lines when it is 0.
- R5: The clock edge that accepts start clears `eval_done`. On the next edge every result byte becomes 0xFF and `line_hits` becomes 0. After reset, every result byte is 0xFF.
- R6: At most eight covering sprites are copied. They go to slots 0, 1, 2 and onward in ascending sprite index, with all four bytes copied. Slots left unused stay 0xFF.
- R7: A covering sprite found while eight slots are already full sets `overflow` and `eval_done` on the same edge, and no further sprites are examined. Exactly eight covering sprites do not set `overflow`.
- R8: `overflow` stays set until a `frame_clr` pulse clears it. A new pass does not clear it.
- R9: Counting the edge that accepts start as edge 0, sprite j is examined at edge j+2. Without overflow, `eval_done` rises at edge 65 and holds until the next start. `line_hits` tracks the running count.
- R10: A start pulse that arrives while a pass is in WIPE or SCAN is ignored, and the pass ends exactly as it would have without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr_wr | input | 1 | Load the byte pointer from host_wdata |
| host_data_wr | input | 1 | Write host_wdata at the pointer, then advance the pointer |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Table byte at the pointer |
| start | input | 1 | Launch a pass when idle or done |
| frame_clr | input | 1 | Clear the overflow flag |
| scanline | input | 8 | Line to test against, held for the whole pass |
| tall_sprites | input | 1 | 1 selects 16-line sprites, 0 selects 8-line sprites |
| sec_sel | input | 5 | Result byte selector |
| sec_byte | output | 8 | Selected result byte |
| line_hits | output | 4 | Number of filled result slots |
| eval_done | output | 1 | Pass finished |
| overflow | output | 1 | Sticky flag for a ninth covering sprite |

## Verification
The properties assume a well-behaved host. It never loads the pointer and writes data in the same cycle. It leaves the table, `scanline` and `tall_sprites` alone while a pass runs. It does not pulse `frame_clr` on the edge where an overflow is detected. The bench drives every input at the falling edge, and it issues host accesses and clear pulses only between passes. Starts that arrive during a pass are the one deliberate exception, used to show that they are ignored.

// File: rtl/spr_eval_pkg.sv
package spr_eval_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WIPE,
        ST_SCAN,
        ST_DONE
    } eval_state_e;

    // lane 0 (low byte) is the top line, lane 3 the horizontal position
    typedef struct packed {
        logic [BYTE_W-1:0] xpos;
        logic [BYTE_W-1:0] attr;
        logic [BYTE_W-1:0] tile;
        logic [BYTE_W-1:0] ytop;
    } spr_entry_t;

    // line covered when it lies in [top, top+height) with no wrap
    function automatic logic line_covered(input logic [BYTE_W-1:0] line,
                                          input logic [BYTE_W-1:0] top,
                                          input logic [BYTE_W:0]   height);
        logic [BYTE_W:0] span;
        span = {1'b0, line} - {1'b0, top};
        return (line >= top) && (span < height);
    endfunction

endpackage

// File: rtl/spr_attr_mem.sv
module spr_attr_mem
    import spr_eval_pkg::*;
#(
    parameter int NUM_SPR = 64,
    localparam int ADDR_W = $clog2(NUM_SPR * LANES),
    localparam int IDX_W  = $clog2(NUM_SPR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_ld,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [ADDR_W-1:0] ptr,
    input  logic [IDX_W-1:0]  scan_idx,
    output spr_entry_t        scan_entry
);

    logic [ADDR_W-1:0]             ptr_q;
    logic [LANES-1:0][BYTE_W-1:0]  lane_host;
    logic [LANES-1:0][BYTE_W-1:0]  lane_scan;
    logic [IDX_W-1:0]              ptr_row;
    logic [1:0]                    ptr_lane;

    assign ptr_row  = ptr_q[ADDR_W-1:2];
    assign ptr_lane = ptr_q[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (addr_ld) begin
            ptr_q <= ADDR_W'(wdata);
        end else if (data_wr) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BYTE_W-1:0] cell_q [NUM_SPR];

        always_ff @(posedge clk) begin
            if (data_wr && !addr_ld && (ptr_lane == 2'(l))) begin
                cell_q[ptr_row] <= wdata;
            end
        end

        assign lane_host[l] = cell_q[ptr_row];
        assign lane_scan[l] = cell_q[scan_idx];
    end

    assign rdata      = lane_host[ptr_lane];
    assign ptr        = ptr_q;
    assign scan_entry = spr_entry_t'(lane_scan);

endmodule

// File: rtl/spr_line_buf.sv
module spr_line_buf
    import spr_eval_pkg::*;
#(
    parameter int SLOTS  = 8,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int SEL_W  = SLOT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  spr_entry_t        wr_entry,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [BYTE_W-1:0] rd_byte
);

    logic [LANES-1:0][BYTE_W-1:0] slot_q [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[s] <= '1;
            end else if (wipe) begin
                slot_q[s] <= '1;
            end else if (wr_en && (wr_slot == SLOT_W'(s))) begin
                slot_q[s] <= wr_entry;
            end
        end
    end

    assign rd_byte = slot_q[rd_sel[SEL_W-1:2]][rd_sel[1:0]];

endmodule

// File: rtl/spr_eval_fsm.sv
module spr_eval_fsm
    import spr_eval_pkg::*;
#(
    parameter int NUM_SPR = 64,
    parameter int SLOTS   = 8,
    parameter int SHORT_H = 8,
    parameter int TALL_H  = 16,
    localparam int IDX_W  = $clog2(NUM_SPR),
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int CNT_W  = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              frame_clr,
    input  logic [BYTE_W-1:0] line,
    input  logic              tall,
    input  logic [BYTE_W-1:0] entry_y,
    output logic [IDX_W-1:0]  scan_idx,
    output logic              wipe,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [CNT_W-1:0]  hits,
    output logic              done,
    output logic              overflow,
    output logic              scanning
);

    eval_state_e       state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  count_q;
    logic              ovf_q;
    logic [BYTE_W:0]   height;
    logic              hit;
    logic              full;
    logic              last;
    logic              ovf_set;

    assign height = tall ? (BYTE_W+1)'(TALL_H) : (BYTE_W+1)'(SHORT_H);
    assign hit    = line_covered(line, entry_y, height);
    assign full   = (count_q == CNT_W'(SLOTS));
    assign last   = (idx_q == IDX_W'(NUM_SPR - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_WIPE;
            ST_WIPE: state_d = ST_SCAN;
            ST_SCAN: if ((hit && full) || last) state_d = ST_DONE;
            ST_DONE: if (start) state_d = ST_WIPE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        wipe     = 1'b0;
        wr_en    = 1'b0;
        ovf_set  = 1'b0;
        done     = 1'b0;
        scanning = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WIPE: wipe = 1'b1;
            ST_SCAN: begin
                scanning = 1'b1;
                wr_en    = hit && !full;
                ovf_set  = hit && full;
            end
            ST_DONE: done = 1'b1;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            if (wipe) begin
                idx_q   <= '0;
                count_q <= '0;
            end else if (scanning) begin
                idx_q <= idx_q + 1'b1;
                if (wr_en) begin
                    count_q <= count_q + 1'b1;
                end
            end
            if (ovf_set) begin
                ovf_q <= 1'b1;
            end else if (frame_clr) begin
                ovf_q <= 1'b0;
            end
        end
    end

    assign scan_idx = idx_q;
    assign wr_slot  = count_q[SLOT_W-1:0];
    assign hits     = count_q;
    assign overflow = ovf_q;

endmodule

// File: rtl/sprite_line_scanner.sv
module sprite_line_scanner
    import spr_eval_pkg::*;
#(
    parameter int NUM_SPR = 64,
    parameter int SLOTS   = 8,
    parameter int SHORT_H = 8,
    parameter int TALL_H  = 16,
    localparam int ADDR_W = $clog2(NUM_SPR * LANES),
    localparam int IDX_W  = $clog2(NUM_SPR),
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int SEL_W  = SLOT_W + 2,
    localparam int CNT_W  = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_addr_wr,
    input  logic              host_data_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              start,
    input  logic              frame_clr,
    input  logic [BYTE_W-1:0] scanline,
    input  logic              tall_sprites,
    input  logic [SEL_W-1:0]  sec_sel,
    output logic [BYTE_W-1:0] sec_byte,
    output logic [CNT_W-1:0]  line_hits,
    output logic              eval_done,
    output logic              overflow
);

    logic [ADDR_W-1:0] host_ptr;
    logic [IDX_W-1:0]  scan_idx;
    spr_entry_t        scan_entry;
    logic              wipe;
    logic              wr_en;
    logic [SLOT_W-1:0] wr_slot;
    logic              scanning;

    spr_attr_mem #(.NUM_SPR(NUM_SPR)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_ld    (host_addr_wr),
        .data_wr    (host_data_wr),
        .wdata      (host_wdata),
        .rdata      (host_rdata),
        .ptr        (host_ptr),
        .scan_idx   (scan_idx),
        .scan_entry (scan_entry)
    );

    spr_eval_fsm #(
        .NUM_SPR (NUM_SPR),
        .SLOTS   (SLOTS),
        .SHORT_H (SHORT_H),
        .TALL_H  (TALL_H)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .frame_clr (frame_clr),
        .line      (scanline),
        .tall      (tall_sprites),
        .entry_y   (scan_entry.ytop),
        .scan_idx  (scan_idx),
        .wipe      (wipe),
        .wr_en     (wr_en),
        .wr_slot   (wr_slot),
        .hits      (line_hits),
        .done      (eval_done),
        .overflow  (overflow),
        .scanning  (scanning)
    );

    spr_line_buf #(.SLOTS(SLOTS)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wipe     (wipe),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .wr_entry (scan_entry),
        .rd_sel   (sec_sel),
        .rd_byte  (sec_byte)
    );

endmodule

// File: rtl/spr_eval_chk.sv
module spr_eval_chk #(
    parameter int SLOTS  = 8,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              frame_clr,
    input logic              host_addr_wr,
    input logic              host_data_wr,
    input logic              eval_done,
    input logic              overflow,
    input logic              scanning,
    input logic [ADDR_W-1:0] host_ptr,
    input logic [CNT_W-1:0]  line_hits
);

    p_ptr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_data_wr && !host_addr_wr) |=> host_ptr == ADDR_W'($past(host_ptr) + 1'b1));

    p_start_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_done && start) |=> !eval_done);

    p_hits_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        line_hits <= CNT_W'(SLOTS));

    p_ovf_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> line_hits == CNT_W'(SLOTS));

    p_ovf_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> eval_done);

    p_ovf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !frame_clr) |=> overflow);

    p_ovf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_clr && !scanning) |=> !overflow);

    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_done && !start) |=> eval_done);

    p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && start) |=> line_hits >= $past(line_hits));

endmodule

bind sprite_line_scanner spr_eval_chk #(
    .SLOTS  (SLOTS),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .frame_clr    (frame_clr),
    .host_addr_wr (host_addr_wr),
    .host_data_wr (host_data_wr),
    .eval_done    (eval_done),
    .overflow     (overflow),
    .scanning     (scanning),
    .host_ptr     (host_ptr),
    .line_hits    (line_hits)
);

// File: tb/tb_sprite_line_scanner.sv
module tb_sprite_line_scanner;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_addr_wr = 1'b0;
    logic       host_data_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       start = 1'b0;
    logic       frame_clr = 1'b0;
    logic [7:0] scanline = '0;
    logic       tall_sprites = 1'b0;
    logic [4:0] sec_sel = '0;
    logic [7:0] sec_byte;
    logic [3:0] line_hits;
    logic       eval_done;
    logic       overflow;

    always #5 clk = ~clk;

    sprite_line_scanner dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_addr_wr (host_addr_wr),
        .host_data_wr (host_data_wr),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .start        (start),
        .frame_clr    (frame_clr),
        .scanline     (scanline),
        .tall_sprites (tall_sprites),
        .sec_sel      (sec_sel),
        .sec_byte     (sec_byte),
        .line_hits    (line_hits),
        .eval_done    (eval_done),
        .overflow     (overflow)
    );

    int   checks = 0;
    int   errors = 0;
    logic [7:0] mem_m [256];
    logic [7:0] ptr_m = '0;
    logic       ovf_m = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic host_load(input logic [7:0] a);
        host_addr_wr = 1'b1;
        host_wdata   = a;
        tick();
        host_addr_wr = 1'b0;
        ptr_m = a;
    endtask

    task automatic host_put(input logic [7:0] d);
        host_data_wr = 1'b1;
        host_wdata   = d;
        tick();
        host_data_wr = 1'b0;
        mem_m[ptr_m] = d;
        ptr_m = ptr_m + 8'd1;
    endtask

    task automatic put_sprite(input int n, input int y, input int t, input int a, input int x);
        host_load(8'(4 * n));
        host_put(8'(y));
        host_put(8'(t));
        host_put(8'(a));
        host_put(8'(x));
    endtask

    // behavioural model of one pass, compared every cycle
    task automatic run_eval(input int line, input bit tall, input int restart_at, input string req);
        int hl[$];
        int ovf_at;
        int h;
        int done_edge;
        ovf_at = -1;
        h = tall ? 16 : 8;
        for (int i = 0; i < 64; i++) begin
            int y;
            y = int'(mem_m[4 * i]);
            if (line >= y && line < y + h) begin
                if (hl.size() < 8) hl.push_back(i);
                else begin
                    ovf_at = i;
                    break;
                end
            end
        end
        done_edge = (ovf_at >= 0) ? ovf_at + 2 : 65;
        scanline     = 8'(line);
        tall_sprites = tall;
        start        = 1'b1;
        tick();
        start = 1'b0;
        chk("R5", "done after start", int'(eval_done), 0);
        for (int n = 1; n <= done_edge + 2; n++) begin
            int eh;
            bit eo;
            start = (n == restart_at);
            tick();
            start = 1'b0;
            eh = 0;
            foreach (hl[k]) if (hl[k] <= n - 2) eh++;
            eo = ovf_m || (ovf_at >= 0 && n >= done_edge);
            chk("R9", "eval_done", int'(eval_done), int'(n >= done_edge));
            chk("R9", "line_hits", int'(line_hits), eh);
            chk((ovf_at >= 0) ? "R7" : "R8", "overflow", int'(overflow), int'(eo));
        end
        if (ovf_at >= 0) ovf_m = 1'b1;
        for (int s = 0; s < 32; s++) begin
            int exp;
            sec_sel = 5'(s);
            #1;
            exp = (s / 4 < hl.size()) ? int'(mem_m[4 * hl[s / 4] + s % 4]) : 8'hFF;
            chk(req, $sformatf("R6 slot byte %0d", s), int'(sec_byte), exp);
            @(negedge clk);
        end
    endtask

    task automatic pulse_clear();
        frame_clr = 1'b1;
        tick();
        frame_clr = 1'b0;
        ovf_m = 1'b0;
        chk("R8", "overflow after clear", int'(overflow), 0);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R5", "reset done", int'(eval_done), 0);
        chk("R8", "reset overflow", int'(overflow), 0);
        chk("R9", "reset hits", int'(line_hits), 0);
        sec_sel = 5'd0;
        #1 chk("R5", "reset byte 0", int'(sec_byte), 8'hFF);
        sec_sel = 5'd31;
        #1 chk("R5", "reset byte 31", int'(sec_byte), 8'hFF);
        @(negedge clk);

        // R1 host pointer behaviour
        host_load(8'h05);
        host_put(8'h11);
        host_put(8'h22);
        host_load(8'h05);
        chk("R1", "read at pointer", int'(host_rdata), 8'h11);
        tick();
        chk("R1", "read does not advance", int'(host_rdata), 8'h11);
        host_load(8'hFF);
        host_put(8'hA5);
        host_put(8'h5A);
        chk("R1", "pointer wrapped", int'(host_rdata), int'(mem_m[ptr_m]));
        host_load(8'h00);
        chk("R1", "wrap write", int'(host_rdata), 8'h5A);
        host_load(8'hFF);
        chk("R1", "byte 255", int'(host_rdata), 8'hA5);

        // fill the table by streaming writes
        host_load(8'h00);
        for (int i = 0; i < 64; i++) begin
            host_put(8'd200);
            host_put(8'(i));
            host_put(8'(i ^ 8'h3c));
            host_put(8'(255 - i));
        end
        host_load(8'h09);
        chk("R2", "tile of sprite 2", int'(host_rdata), 2);

        // R3/R4 coverage rule and height select
        put_sprite(3, 50, 8'h31, 8'h01, 8'h10);
        put_sprite(10, 43, 8'h32, 8'h02, 8'h20);
        put_sprite(20, 42, 8'h33, 8'h03, 8'h30);
        put_sprite(40, 35, 8'h34, 8'h04, 8'h40);
        put_sprite(41, 34, 8'h35, 8'h05, 8'h50);
        put_sprite(50, 51, 8'h36, 8'h06, 8'h60);
        run_eval(50, 1'b0, -1, "R3");
        run_eval(50, 1'b1, -1, "R4");

        // R5 wipe leaves all ones when nothing covers the line
        run_eval(100, 1'b0, -1, "R5");

        // R3 top-of-range, no wrap past 255
        put_sprite(60, 250, 8'h77, 8'h88, 8'h99);
        run_eval(255, 1'b0, -1, "R3");
        run_eval(249, 1'b1, -1, "R3");

        // R7 overflow on the ninth cover
        for (int i = 21; i <= 30; i++) put_sprite(i, 120, 8'h40 + i, i, 2 * i);
        run_eval(125, 1'b0, -1, "R7");
        run_eval(50, 1'b0, -1, "R8");
        pulse_clear();

        // exactly eight covers: no overflow
        put_sprite(29, 200, 1, 2, 3);
        put_sprite(30, 200, 4, 5, 6);
        run_eval(122, 1'b0, -1, "R7");

        // R10 start while busy is ignored
        run_eval(50, 1'b1, 1, "R10");
        run_eval(50, 1'b1, 20, "R10");
        run_eval(125, 1'b1, 10, "R10");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule